// File: doc/BRIEF.md
# Performance State Boost Controller

This block chooses the voltage and frequency operating point of a single core. Software names one of five visible performance levels through a small register port. When the core is asked to run at the fastest visible level and enough thermal headroom has been saved, the controller raises the core on its own into one of two faster boost levels that software cannot name. Headroom is kept as a credit count. Credit grows in each power sample period whose reading is below the design power limit, and boosting uses it up every cycle.

Each change of operating point costs time. The controller drives a voltage code and a frequency code to the regulator and the clock generator. It waits for a done pulse after each of the two steps and shows busy for the whole change. When performance goes up, the voltage moves first. When it goes down, the frequency moves first. A thermal emergency input overrides all of this: it drops the core at once to the slowest level and empties the credit.

Top module: `pboost_ctrl`

## Requirements
- R1: After reset the current level index is 6 (the slowest level), the requested index is 6, busy is 0, credit is 0, the credit ceiling is 1000, volt_code is 750 and freq_code is 9.
- R2: Level index 0..6 maps to the pairs (volt_code in mV, freq_code in 100 MHz units): 0:(1000,24), 1:(875,18), 2:(825,16), 3:(812,14), 4:(787,13), 5:(762,11), 6:(750,9). Indices 0 and 1 are the boost levels.
- R3: A write to address 0 sets the requested index only when the whole write word is in 2..6 and busy is 0. Any other value, or any write made while busy, leaves the requested index unchanged.
- R4: Raising performance moves volt_code first; freq_code follows on the first xn_done. Lowering performance moves freq_code first; volt_code follows on the first xn_done. The current index takes the target on the second xn_done, and busy then falls. busy rises one cycle after a new target is chosen.
- R5: Each cycle with pwr_valid high and pwr_sample below 100 adds (100 − pwr_sample) to the credit. A sample at or above 100 adds nothing.
- R6: Credit drops by 8 per cycle at level 0 and by 3 per cycle at level 1. It saturates at 0 and at the ceiling, which is written at address 1 (bits 11:0).
- R7: With index 2 requested, the target is level 0 when credit is at least 400, level 1 when credit is in 100..399, and level 2 otherwise. With any other index requested, the target is that index.
- R8: When credit falls below a boost threshold, the controller steps down: from level 0 to level 1, and from level 1 to the requested level 2.
- R9: therm_emerg high at a clock edge sets the current index to 6 and the codes to (750,9), clears the credit, ends any change in progress and drops busy, all at that edge.
- R10: Read data is combinational on reg_addr: 0 is the requested index, 1 is the credit ceiling, 2 is {busy at bit 3, current index at bits 2:0}, and 3 is the credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| pwr_valid | input | 1 | Power sample valid, one pulse per sample period |
| pwr_sample | input | 8 | Measured power sample |
| therm_emerg | input | 1 | Thermal emergency |
| xn_done | input | 1 | Regulator or clock step finished |
| volt_code | output | 10 | Voltage request in mV |
| freq_code | output | 5 | Frequency request in 100 MHz units |
| busy | output | 1 | Operating point change in progress |

## Verification
A wrong credit value shows up in the credit readback in the next cycle. It also shows up as a boost entered or left at the wrong credit level, which can be seen as busy rising one cycle after the threshold is crossed. A wrong sequencer phase shows up at once as the wrong code moving first, or as busy staying high or falling on the wrong xn_done. A wrong current index makes the following change pick the wrong direction, so the first code to move is the wrong one. The bench therefore checks which code moves first, the per-cycle credit drop at each boost level, and the readback straight after each edge that matters.

// File: rtl/pboost_pkg.sv
package pboost_pkg;
  localparam int IDX_W = 3;
  localparam int VC_W  = 10;
  localparam int FC_W  = 5;

  localparam logic [IDX_W-1:0] IDX_PB0 = 3'd0;
  localparam logic [IDX_W-1:0] IDX_PB1 = 3'd1;
  localparam logic [IDX_W-1:0] IDX_TOP = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LOW = 3'd6;

  typedef enum logic [1:0] {PH_IDLE, PH_STEP1, PH_STEP2} phase_e;

  function automatic logic [VC_W-1:0] volt_of(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    volt_of = 10'd1000;
      3'd1:    volt_of = 10'd875;
      3'd2:    volt_of = 10'd825;
      3'd3:    volt_of = 10'd812;
      3'd4:    volt_of = 10'd787;
      3'd5:    volt_of = 10'd762;
      default: volt_of = 10'd750;
    endcase
  endfunction

  function automatic logic [FC_W-1:0] freq_of(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    freq_of = 5'd24;
      3'd1:    freq_of = 5'd18;
      3'd2:    freq_of = 5'd16;
      3'd3:    freq_of = 5'd14;
      3'd4:    freq_of = 5'd13;
      3'd5:    freq_of = 5'd11;
      default: freq_of = 5'd9;
    endcase
  endfunction
endpackage

// File: rtl/pb_credit.sv
module pb_credit #(
  parameter int PWR_W  = 8,
  parameter int CRED_W = 12,
  parameter int LIMIT  = 100,
  parameter int COST0  = 8,
  parameter int COST1  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_valid,
  input  logic [PWR_W-1:0]  smp,
  input  logic              in_pb0,
  input  logic              in_pb1,
  input  logic [CRED_W-1:0] cmax,
  output logic [CRED_W-1:0] credit
);
  localparam int SUM_W = CRED_W + 2;
  localparam logic [PWR_W-1:0] LIM = PWR_W'(LIMIT);

  logic [SUM_W-1:0]  gain, cost, sum, net;
  logic [CRED_W-1:0] cred_q, cred_n;
  logic              cred_en;

  always_comb begin
    gain = '0;
    if (smp_valid && (smp < LIM)) gain = SUM_W'(LIM - smp);
    if (in_pb0)      cost = SUM_W'(COST0);
    else if (in_pb1) cost = SUM_W'(COST1);
    else             cost = '0;
    sum = SUM_W'(cred_q) + gain;
    net = (sum > cost) ? (sum - cost) : '0;
    if (clr)                     cred_n = '0;
    else if (net > SUM_W'(cmax)) cred_n = cmax;
    else                         cred_n = net[CRED_W-1:0];
    cred_en = clr | smp_valid | in_pb0 | in_pb1 | (cred_q > cmax);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cred_q <= '0;
    else if (cred_en) cred_q <= cred_n;
  end

  assign credit = cred_q;
endmodule

// File: rtl/pb_policy.sv
module pb_policy
  import pboost_pkg::*;
#(
  parameter int CRED_W = 12,
  parameter int HI_TH  = 400,
  parameter int LO_TH  = 100
) (
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [CRED_W-1:0] credit,
  output logic [IDX_W-1:0]  want_idx
);
  always_comb begin
    want_idx = req_idx;
    if (req_idx == IDX_TOP) begin
      if (credit >= CRED_W'(HI_TH))      want_idx = IDX_PB0;
      else if (credit >= CRED_W'(LO_TH)) want_idx = IDX_PB1;
    end
  end
endmodule

// File: rtl/pb_seq.sv
module pb_seq
  import pboost_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emerg,
  input  logic             done,
  input  logic [IDX_W-1:0] want_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] tgt_idx,
  output logic [VC_W-1:0]  vcode,
  output logic [FC_W-1:0]  fcode,
  output logic             busy
);
  phase_e           ph_q, ph_n;
  logic [IDX_W-1:0] cur_q, cur_n, tgt_q, tgt_n;
  logic [VC_W-1:0]  v_q, v_n;
  logic [FC_W-1:0]  f_q, f_n;

  always_comb begin
    ph_n  = ph_q;
    cur_n = cur_q;
    tgt_n = tgt_q;
    v_n   = v_q;
    f_n   = f_q;
    if (emerg) begin
      ph_n  = PH_IDLE;
      cur_n = IDX_LOW;
      tgt_n = IDX_LOW;
      v_n   = volt_of(IDX_LOW);
      f_n   = freq_of(IDX_LOW);
    end else begin
      case (ph_q)
        PH_IDLE: if (want_idx != cur_q) begin
          tgt_n = want_idx;
          ph_n  = PH_STEP1;
          if (want_idx < cur_q) v_n = volt_of(want_idx);
          else                  f_n = freq_of(want_idx);
        end
        PH_STEP1: if (done) begin
          ph_n = PH_STEP2;
          if (tgt_q < cur_q) f_n = freq_of(tgt_q);
          else               v_n = volt_of(tgt_q);
        end
        PH_STEP2: if (done) begin
          ph_n  = PH_IDLE;
          cur_n = tgt_q;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cur_q <= IDX_LOW;
      tgt_q <= IDX_LOW;
      v_q   <= volt_of(IDX_LOW);
      f_q   <= freq_of(IDX_LOW);
    end else begin
      ph_q  <= ph_n;
      cur_q <= cur_n;
      tgt_q <= tgt_n;
      v_q   <= v_n;
      f_q   <= f_n;
    end
  end

  assign cur_idx = cur_q;
  assign tgt_idx = tgt_q;
  assign vcode   = v_q;
  assign fcode   = f_q;
  assign busy    = (ph_q != PH_IDLE);
endmodule

// File: rtl/pboost_ctrl.sv
module pboost_ctrl
  import pboost_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PWR_W    = 8,
  parameter int CRED_W   = 12,
  parameter int LIMIT    = 100,
  parameter int COST0    = 8,
  parameter int COST1    = 3,
  parameter int HI_TH    = 400,
  parameter int LO_TH    = 100,
  parameter int CMAX_RST = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pwr_valid,
  input  logic [PWR_W-1:0]  pwr_sample,
  input  logic              therm_emerg,
  input  logic              xn_done,
  output logic [VC_W-1:0]   volt_code,
  output logic [FC_W-1:0]   freq_code,
  output logic              busy
);
  logic [IDX_W-1:0]  req_q, cur_idx, tgt_idx, want_idx;
  logic [CRED_W-1:0] cmax_q, credit;
  logic              req_en, cmax_en, req_ok;
  logic              unused_wd_hi;

  assign req_ok  = (reg_wdata >= DATA_W'(IDX_TOP)) && (reg_wdata <= DATA_W'(IDX_LOW));
  assign req_en  = reg_wr && (reg_addr == 2'd0) && req_ok && !busy;
  assign cmax_en = reg_wr && (reg_addr == 2'd1);
  assign unused_wd_hi = ^reg_wdata[DATA_W-1:CRED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= IDX_LOW;
      cmax_q <= CRED_W'(CMAX_RST);
    end else begin
      if (req_en)  req_q  <= reg_wdata[IDX_W-1:0];
      if (cmax_en) cmax_q <= reg_wdata[CRED_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DATA_W'(req_q);
      2'd1:    reg_rdata = DATA_W'(cmax_q);
      2'd2:    reg_rdata = DATA_W'({busy, cur_idx});
      default: reg_rdata = DATA_W'(credit);
    endcase
  end

  pb_credit #(
    .PWR_W(PWR_W), .CRED_W(CRED_W), .LIMIT(LIMIT), .COST0(COST0), .COST1(COST1)
  ) u_credit (
    .clk(clk), .rst_n(rst_n), .clr(therm_emerg), .smp_valid(pwr_valid),
    .smp(pwr_sample), .in_pb0(cur_idx == IDX_PB0), .in_pb1(cur_idx == IDX_PB1),
    .cmax(cmax_q), .credit(credit)
  );

  pb_policy #(.CRED_W(CRED_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_policy (
    .req_idx(req_q), .credit(credit), .want_idx(want_idx)
  );

  pb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .emerg(therm_emerg), .done(xn_done),
    .want_idx(want_idx), .cur_idx(cur_idx), .tgt_idx(tgt_idx),
    .vcode(volt_code), .fcode(freq_code), .busy(busy)
  );
endmodule

// File: rtl/pboost_ctrl_chk.sv
module pboost_ctrl_chk #(
  parameter int CRED_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              emerg,
  input logic              busy,
  input logic              wr_req,
  input logic [2:0]        cur,
  input logic [2:0]        req,
  input logic [2:0]        tgt,
  input logic [CRED_W-1:0] credit,
  input logic [CRED_W-1:0] cmax,
  input logic [9:0]        vcode,
  input logic [4:0]        fcode
);
  // R3: request register frozen while a change is in flight
  p_busy_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_req) |=> $stable(req));

  // R4: exactly one of the two codes moves as a change begins
  p_one_code_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !emerg) |-> ($stable(vcode) != $stable(fcode)));

  // R6: credit never exceeds the ceiling seen on the previous edge
  p_credit_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (credit <= $past(cmax)));

  // R7: a boost target is only chosen with the top visible level requested
  p_boost_needs_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (tgt < 3'd2)) |-> ($past(req) == 3'd2));

  // R9: emergency lands on the slowest level with no credit and idle
  p_emerg_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emerg |=> ((cur == 3'd6) && (credit == '0) && !busy && (vcode == 10'd750)));

  // R2: current index stays inside the table
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= 3'd6);
endmodule

bind pboost_ctrl pboost_ctrl_chk #(.CRED_W(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .emerg(therm_emerg), .busy(busy),
  .wr_req(reg_wr && (reg_addr == 2'd0)), .cur(cur_idx), .req(req_q),
  .tgt(tgt_idx), .credit(credit), .cmax(cmax_q), .vcode(volt_code),
  .fcode(freq_code)
);

// File: tb/test_pboost_ctrl.sv
module test_pboost_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pwr_valid = 1'b0;
  logic [7:0]  pwr_sample = '0;
  logic        therm_emerg = 1'b0;
  logic        xn_done = 1'b0;
  logic [9:0]  volt_code;
  logic [4:0]  freq_code;
  logic        busy;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  pboost_ctrl i_pboost_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_valid(pwr_valid),
    .pwr_sample(pwr_sample), .therm_emerg(therm_emerg), .xn_done(xn_done),
    .volt_code(volt_code), .freq_code(freq_code), .busy(busy)
  );

  // {write data, expected request, expected current, volt, freq}
  localparam logic [28:0] TBL [9] = '{
    {8'd6, 3'd6, 3'd6, 10'd750, 5'd9},
    {8'd2, 3'd2, 3'd2, 10'd825, 5'd16},
    {8'd0, 3'd2, 3'd2, 10'd825, 5'd16},
    {8'd3, 3'd3, 3'd3, 10'd812, 5'd14},
    {8'd1, 3'd3, 3'd3, 10'd812, 5'd14},
    {8'd4, 3'd4, 3'd4, 10'd787, 5'd13},
    {8'd7, 3'd4, 3'd4, 10'd787, 5'd13},
    {8'd5, 3'd5, 3'd5, 10'd762, 5'd11},
    {8'd6, 3'd6, 3'd6, 10'd750, 5'd9}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ack();
    xn_done = 1'b1;
    @(negedge clk);
    xn_done = 1'b0;
  endtask

  task automatic smp(input logic [7:0] s);
    pwr_valid = 1'b1; pwr_sample = s;
    @(negedge clk);
    pwr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    for (int n = 0; n < 10 && busy; n++) ack();
  endtask

  task automatic wait_busy();
    for (int n = 0; n < 400 && !busy; n++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int v, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 readback layout
    rd(2'd0, v); check(v == 6, "R1 req", v, 6);
    rd(2'd2, v); check(v == 6, "R1 R10 status", v, 6);
    rd(2'd3, v); check(v == 0, "R1 credit", v, 0);
    rd(2'd1, v); check(v == 1000, "R1 R10 ceiling", v, 1000);
    check(volt_code == 750 && freq_code == 9, "R1 codes", volt_code, 750);

    // R2 R3 table walk
    foreach (TBL[i]) begin
      wr(2'd0, {8'd0, TBL[i][28:21]});
      settle();
      rd(2'd0, v); check(v == int'(TBL[i][20:18]), "R3 req readback", v, int'(TBL[i][20:18]));
      rd(2'd2, v); check(v == int'(TBL[i][17:15]), "R2 cur", v, int'(TBL[i][17:15]));
      check(volt_code == TBL[i][14:5], "R2 volt", volt_code, int'(TBL[i][14:5]));
      check(freq_code == TBL[i][4:0], "R2 freq", freq_code, int'(TBL[i][4:0]));
    end

    // R3 upper bits make the word out of range
    wr(2'd0, 16'h0104); settle();
    rd(2'd0, v); check(v == 6, "R3 wide word ignored", v, 6);

    // R5 credit gain
    smp(8'd40);  rd(2'd3, v); check(v == 60, "R5 gain", v, 60);
    smp(8'd100); rd(2'd3, v); check(v == 60, "R5 at limit", v, 60);
    smp(8'd150); rd(2'd3, v); check(v == 60, "R5 above limit", v, 60);

    // R6 ceiling saturation
    wr(2'd1, 16'd200);
    rd(2'd1, v); check(v == 200, "R10 ceiling write", v, 200);
    smp(8'd0); smp(8'd0);
    rd(2'd3, v); check(v == 200, "R6 sat max", v, 200);
    wr(2'd1, 16'd1000);
    smp(8'd0); smp(8'd0); smp(8'd0);
    rd(2'd3, v); check(v == 500, "R5 accumulate", v, 500);

    // R7 boost to level 0, R4 voltage first on raise
    wr(2'd0, 16'd2);
    @(negedge clk);
    check(busy == 1'b1, "R4 busy", busy, 1);
    check(volt_code == 1000 && freq_code == 9, "R4 R7 volt first", freq_code, 9);
    ack();
    check(freq_code == 24 && volt_code == 1000, "R4 freq second", freq_code, 24);
    check(busy == 1'b1, "R4 still busy", busy, 1);
    ack();
    rd(2'd2, v); check(v == 0, "R4 cur level 0", v, 0);
    rd(2'd3, c1); @(negedge clk); rd(2'd3, c2);
    check(c1 - c2 == 8, "R6 cost level 0", c1 - c2, 8);

    // R8 step to level 1, lowering moves frequency first
    wait_busy();
    rd(2'd3, v); check(v < 400 && v >= 100, "R8 credit at step", v, 399);
    check(freq_code == 18 && volt_code == 1000, "R4 R8 freq first", freq_code, 18);
    ack(); ack();
    rd(2'd2, v); check(v == 1, "R8 cur level 1", v, 1);
    rd(2'd3, c1); @(negedge clk); rd(2'd3, c2);
    check(c1 - c2 == 3, "R6 cost level 1", c1 - c2, 3);

    // R8 fall back to requested level 2
    wait_busy();
    check(freq_code == 16 && volt_code == 875, "R8 fallback freq first", freq_code, 16);
    repeat (40) @(negedge clk);
    rd(2'd3, v); check(v == 0, "R6 sat zero", v, 0);
    ack(); ack();
    rd(2'd2, v); check(v == 2, "R8 cur level 2", v, 2);

    // R4 software lowering, R3 write while busy
    wr(2'd0, 16'd5);
    @(negedge clk);
    check(freq_code == 11 && volt_code == 825, "R4 lower freq first", freq_code, 11);
    wr(2'd0, 16'd6);
    rd(2'd0, v); check(v == 5, "R3 busy write ignored", v, 5);
    ack(); ack();
    rd(2'd2, v); check(v == 5, "R4 cur 5", v, 5);

    // R7 middle band, R9 emergency mid change
    smp(8'd0); smp(8'd0); smp(8'd0);
    wr(2'd0, 16'd2);
    @(negedge clk);
    check(volt_code == 875 && freq_code == 11, "R7 level 1 chosen", volt_code, 875);
    therm_emerg = 1'b1; pwr_valid = 1'b1; pwr_sample = 8'd0;
    @(negedge clk);
    therm_emerg = 1'b0; pwr_valid = 1'b0;
    rd(2'd2, v); check(v == 6, "R9 status", v, 6);
    rd(2'd3, v); check(v == 0, "R9 credit cleared", v, 0);
    check(volt_code == 750 && freq_code == 9, "R9 codes", volt_code, 750);
    settle();
    rd(2'd2, v); check(v == 2, "R9 R7 resume level 2", v, 2);

    finish_run();
  end
endmodule